// File: doc/BRIEF.md
# Merging Cell Reassembler

This block sits on the output side of one port of a cell switch. Each arriving cell carries the number of the input port it came from and the circuit label it used on that input. Together these two fields select a reassembly queue. A cell waits in its queue until the cell that closes its packet arrives. At that point the whole packet joins the single output queue in one step. Cells of different packets therefore never mix on the output, even when several incoming circuits share one outgoing label.

All queues draw their slots from one shared pool of cell storage. Each queue is a linked list threaded through a next-slot array. A completed packet is spliced onto the output list in the same clock edge that stores its last cell. The outgoing label comes from a translation table indexed by the circuit. When the pool runs out, the partial packet on the affected circuit is thrown away, and the rest of it is skipped until its closing cell has passed.

Top module: `cmr_top`

## Requirements
- R1: `in_ready` is 0 while `rst_n` is low and is 1 from the first clock edge after reset is released. `out_valid` is 0 during reset.
- R2: No cell of a packet is offered on the output before the clock edge that stores that packet's closing cell (`in_eop`=1). `out_valid` is 1 exactly while at least one completed cell is still waiting to leave.
- R3: Once a packet's first cell is accepted at the output, its remaining cells are offered without any cell of another packet between them. This holds even when the input interleaves cells of several circuits.
- R4: Packets leave in the order in which their closing cells were accepted at the input. Within a packet, cells leave in arrival order with the payload unchanged, and `out_eop` is 1 only on the last cell.
- R5: Every cell of a packet leaves with `out_label` equal to the table entry at index {`in_port`,`in_vci`} (port in the upper bits), written through `tbl_we`/`tbl_circ`/`tbl_label`. Circuits whose entries hold the same value leave under the same label.
- R6: Circuits that differ only in the low bit of `in_vci` (the service class) can be given different outgoing labels, because each circuit has its own table entry.
- R7: A single cell with `in_eop`=1 forms a complete one-cell packet.
- R8: The pool holds POOL_DEPTH-1 cells in total, counting both partial and completed packets, in any split across circuits. A single circuit may fill all of them.
- R9: A cell that arrives while POOL_DEPTH-1 cells are held is dropped, and its circuit's stored partial cells are released. If that cell was not a closing cell, later cells of the same circuit are dropped up to and including the next closing cell. Other circuits' packets are unaffected.
- R10: While `out_valid`=1 and `out_ready`=0, `out_data`, `out_eop` and `out_label` hold their values (the table is not written). A slot returns to the pool only on the edge where its cell is accepted, and the pool-full test in R9 uses the occupancy from before that edge's release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input cell present |
| in_ready | output | 1 | Input cell accepted when high |
| in_port | input | PORT_W | Input port number of the cell |
| in_vci | input | VCI_W | Incoming circuit label; bit 0 is the service class |
| in_eop | input | 1 | Cell closes its packet |
| in_data | input | DATA_W | Cell payload word |
| tbl_we | input | 1 | Translation table write strobe |
| tbl_circ | input | PORT_W+VCI_W | Circuit index {port,label} to write |
| tbl_label | input | OLBL_W | Outgoing label to store |
| out_valid | output | 1 | Output cell present |
| out_ready | input | 1 | Downstream accepts the output cell |
| out_label | output | OLBL_W | Translated outgoing label |
| out_eop | output | 1 | Output cell closes its packet |
| out_data | output | DATA_W | Output payload word |

## Verification
Two events can land on one clock edge. A packet's closing cell can arrive while the output accepts the only remaining cell of its list. Likewise, a cell can arrive at a full pool in the same edge that the output frees a slot. The bench forces both by stalling `out_ready` to build the exact occupancy, then raising it in the cycle the critical input cell is presented. A reference model decides from the requirements whether the cell is kept or dropped, and which packet must lead the output. Long interleaved sweeps over all circuit pairs and a pseudo-random phase with random backpressure repeat these coincidences many times.

// File: rtl/cmr_pkg.sv
// Shared definitions for the merging cell reassembler.
package cmr_pkg;
    // Per-circuit collection mode: gather cells, or skip up to the next closing cell.
    typedef enum logic [0:0] {
        Q_COLLECT = 1'b0,
        Q_SKIP    = 1'b1
    } qmode_e;
endpackage

// File: rtl/cmr_label_map.sv
// Outgoing label table. Reads are combinational by circuit index. The label of
// the packet now at the output head is captured when its first cell is accepted
// and held until its last cell leaves, so one packet carries one label.
// Assumes: adv is asserted only when a cell is offered and accepted.
module cmr_label_map #(
    parameter int CIRC_W = 3,
    parameter int OLBL_W = 4,
    localparam int NCIRC = 1 << CIRC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CIRC_W-1:0] waddr,
    input  logic [OLBL_W-1:0] wdata,
    input  logic [CIRC_W-1:0] rd_circ,
    input  logic              adv,
    input  logic              adv_eop,
    output logic [OLBL_W-1:0] label
);
    logic [OLBL_W-1:0] tbl [NCIRC];
    logic              mid_pkt;
    logic [OLBL_W-1:0] held;

    // Table storage with a single write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCIRC; i++) tbl[i] <= '0;
        end else if (we) begin
            tbl[waddr] <= wdata;
        end
    end

    // Track whether the output is inside a packet and hold its label.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mid_pkt <= 1'b0;
            held    <= '0;
        end else if (adv) begin
            mid_pkt <= !adv_eop;
            if (!mid_pkt) held <= tbl[rd_circ];
        end
    end

    assign label = mid_pkt ? held : tbl[rd_circ];
endmodule

// File: rtl/cmr_free_list.sv
// Linked free list of pool slots. One slot is always kept at the tail, so a
// pop at the head and an append at the tail never touch the same node.
// Appends a released slot and/or a discarded chain; it emits up to two
// next-pointer writes for the parent's link array.
// Assumes: alloc only when avail; chain_vld only when !avail.
module cmr_free_list #(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc,
    input  logic [PTR_W-1:0] link_of_head,
    input  logic             rel_vld,
    input  logic [PTR_W-1:0] rel_slot,
    input  logic             chain_vld,
    input  logic [PTR_W-1:0] chain_h,
    input  logic [PTR_W-1:0] chain_t,
    input  logic [CNT_W-1:0] chain_len,
    output logic [PTR_W-1:0] head,
    output logic             avail,
    output logic [CNT_W-1:0] cnt,
    output logic             lw0_en,
    output logic [PTR_W-1:0] lw0_addr,
    output logic [PTR_W-1:0] lw0_data,
    output logic             lw1_en,
    output logic [PTR_W-1:0] lw1_addr,
    output logic [PTR_W-1:0] lw1_data
);
    logic [PTR_W-1:0] tail;

    assign avail = cnt >= CNT_W'(2);

    // Link writes: chain onto the tail, then the released slot after it.
    always_comb begin
        lw0_en   = chain_vld | rel_vld;
        lw0_addr = tail;
        lw0_data = chain_vld ? chain_h : rel_slot;
        lw1_en   = chain_vld & rel_vld;
        lw1_addr = chain_t;
        lw1_data = rel_slot;
    end

    // Head, tail and population of the free list.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head <= '0;
            tail <= PTR_W'(DEPTH - 1);
            cnt  <= CNT_W'(DEPTH);
        end else begin
            if (alloc) head <= link_of_head;
            if (rel_vld) tail <= rel_slot;
            else if (chain_vld) tail <= chain_t;
            cnt <= cnt + (chain_vld ? chain_len : '0) + CNT_W'(rel_vld) - CNT_W'(alloc);
        end
    end
endmodule

// File: rtl/cmr_out_list.sv
// Output list of completed cells. A completed packet segment is spliced onto
// the tail in one edge; the head cell leaves on each accepted transfer.
// Assumes: pop only when cnt != 0.
module cmr_out_list #(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             splice,
    input  logic [PTR_W-1:0] seg_h,
    input  logic [PTR_W-1:0] seg_t,
    input  logic [CNT_W-1:0] seg_len,
    input  logic             pop,
    input  logic [PTR_W-1:0] link_of_head,
    output logic [PTR_W-1:0] head,
    output logic [CNT_W-1:0] cnt,
    output logic             lw_en,
    output logic [PTR_W-1:0] lw_addr,
    output logic [PTR_W-1:0] lw_data
);
    logic [PTR_W-1:0] tail;
    logic             goes_empty;

    // The list is empty, or its last cell leaves in this edge.
    assign goes_empty = (cnt == '0) | (pop & (cnt == CNT_W'(1)));

    // Link the old tail to the new segment unless the list restarts.
    always_comb begin
        lw_en   = splice & !goes_empty;
        lw_addr = tail;
        lw_data = seg_h;
    end

    // Head, tail and population of the output list.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head <= '0;
            tail <= '0;
            cnt  <= '0;
        end else begin
            if (splice && goes_empty) head <= seg_h;
            else if (pop) head <= link_of_head;
            if (splice) tail <= seg_t;
            cnt <= cnt + (splice ? seg_len : '0) - CNT_W'(pop);
        end
    end
endmodule

// File: rtl/cmr_top.sv
// Merging cell reassembler. Cells are collected per circuit {port,label} in
// linked lists inside one shared slot pool. A packet is spliced whole onto the
// output list when its closing cell is stored. Labels are translated at the
// output. When the pool is full, the circuit's partial packet is discarded.
// Assumes: one input cell per clock; POOL_DEPTH is a power of two.
module cmr_top
    import cmr_pkg::*;
#(
    parameter int PORT_W     = 1,
    parameter int VCI_W      = 2,
    parameter int DATA_W     = 8,
    parameter int OLBL_W     = 4,
    parameter int POOL_DEPTH = 8,
    localparam int CIRC_W = PORT_W + VCI_W,
    localparam int NCIRC  = 1 << CIRC_W,
    localparam int PTR_W  = $clog2(POOL_DEPTH),
    localparam int CNT_W  = $clog2(POOL_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [PORT_W-1:0] in_port,
    input  logic [VCI_W-1:0]  in_vci,
    input  logic              in_eop,
    input  logic [DATA_W-1:0] in_data,
    input  logic              tbl_we,
    input  logic [CIRC_W-1:0] tbl_circ,
    input  logic [OLBL_W-1:0] tbl_label,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [OLBL_W-1:0] out_label,
    output logic              out_eop,
    output logic [DATA_W-1:0] out_data
);
    logic              rdy_q;
    logic [CIRC_W-1:0] cid;
    logic              take, skip, store, drop, pop;
    logic [PTR_W-1:0]  q_head [NCIRC];
    logic [PTR_W-1:0]  q_tail [NCIRC];
    logic [CNT_W-1:0]  q_cnt  [NCIRC];
    qmode_e            q_mode [NCIRC];
    logic [CNT_W-1:0]  cur_cnt;
    logic [PTR_W-1:0]  link     [POOL_DEPTH];
    logic [DATA_W-1:0] data_mem [POOL_DEPTH];
    logic              eop_mem  [POOL_DEPTH];
    logic [CIRC_W-1:0] circ_mem [POOL_DEPTH];
    logic [PTR_W-1:0]  fl_slot, fl_lw0_addr, fl_lw0_data, fl_lw1_addr, fl_lw1_data;
    logic              fl_avail, fl_lw0_en, fl_lw1_en;
    logic [CNT_W-1:0]  fl_cnt;
    logic [PTR_W-1:0]  ol_head, ol_lw_addr, ol_lw_data;
    logic [CNT_W-1:0]  ol_cnt;
    logic              ol_lw_en;
    logic [NCIRC*CNT_W-1:0] q_cnt_flat;

    // Input is accepted from the first edge after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) rdy_q <= 1'b0;
        else        rdy_q <= 1'b1;
    end

    assign in_ready = rdy_q;
    assign cid      = {in_port, in_vci};
    assign cur_cnt  = q_cnt[cid];
    assign take     = in_valid & rdy_q;
    assign skip     = take & (q_mode[cid] == Q_SKIP);
    assign store    = take & !skip & fl_avail;
    assign drop     = take & !skip & !fl_avail;
    assign pop      = out_valid & out_ready;

    // Per-circuit list state: append, complete, drop and skip.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCIRC; i++) begin
                q_head[i] <= '0;
                q_tail[i] <= '0;
                q_cnt[i]  <= '0;
                q_mode[i] <= Q_COLLECT;
            end
        end else if (take) begin
            if (skip) begin
                if (in_eop) q_mode[cid] <= Q_COLLECT;
            end else if (store) begin
                if (in_eop) begin
                    q_cnt[cid] <= '0;
                end else begin
                    if (cur_cnt == '0) q_head[cid] <= fl_slot;
                    q_tail[cid] <= fl_slot;
                    q_cnt[cid]  <= cur_cnt + CNT_W'(1);
                end
            end else begin
                q_cnt[cid] <= '0;
                if (!in_eop) q_mode[cid] <= Q_SKIP;
            end
        end
    end

    // Cell payload storage written on every stored cell.
    always_ff @(posedge clk) begin
        if (store) begin
            data_mem[fl_slot] <= in_data;
            eop_mem[fl_slot]  <= in_eop;
            circ_mem[fl_slot] <= cid;
        end
    end

    // Next-slot array shared by all lists; the writers target disjoint lists.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < POOL_DEPTH; i++) link[i] <= PTR_W'((i + 1) % POOL_DEPTH);
        end else begin
            if (store && cur_cnt != '0) link[q_tail[cid]] <= fl_slot;
            if (ol_lw_en)  link[ol_lw_addr]  <= ol_lw_data;
            if (fl_lw0_en) link[fl_lw0_addr] <= fl_lw0_data;
            if (fl_lw1_en) link[fl_lw1_addr] <= fl_lw1_data;
        end
    end

    cmr_free_list #(.DEPTH(POOL_DEPTH)) u_free (
        .clk(clk), .rst_n(rst_n),
        .alloc(store), .link_of_head(link[fl_slot]),
        .rel_vld(pop), .rel_slot(ol_head),
        .chain_vld(drop && cur_cnt != '0), .chain_h(q_head[cid]), .chain_t(q_tail[cid]),
        .chain_len(cur_cnt),
        .head(fl_slot), .avail(fl_avail), .cnt(fl_cnt),
        .lw0_en(fl_lw0_en), .lw0_addr(fl_lw0_addr), .lw0_data(fl_lw0_data),
        .lw1_en(fl_lw1_en), .lw1_addr(fl_lw1_addr), .lw1_data(fl_lw1_data)
    );

    cmr_out_list #(.DEPTH(POOL_DEPTH)) u_out (
        .clk(clk), .rst_n(rst_n),
        .splice(store && in_eop),
        .seg_h((cur_cnt == '0) ? fl_slot : q_head[cid]),
        .seg_t(fl_slot),
        .seg_len(cur_cnt + CNT_W'(1)),
        .pop(pop), .link_of_head(link[ol_head]),
        .head(ol_head), .cnt(ol_cnt),
        .lw_en(ol_lw_en), .lw_addr(ol_lw_addr), .lw_data(ol_lw_data)
    );

    cmr_label_map #(.CIRC_W(CIRC_W), .OLBL_W(OLBL_W)) u_lbl (
        .clk(clk), .rst_n(rst_n),
        .we(tbl_we), .waddr(tbl_circ), .wdata(tbl_label),
        .rd_circ(circ_mem[ol_head]), .adv(pop), .adv_eop(out_eop),
        .label(out_label)
    );

    assign out_valid = ol_cnt != '0;
    assign out_data  = data_mem[ol_head];
    assign out_eop   = eop_mem[ol_head];

    // Flattened per-circuit counts for the checker.
    for (genvar g = 0; g < NCIRC; g++) begin : g_cnt
        assign q_cnt_flat[g*CNT_W +: CNT_W] = q_cnt[g];
    end
endmodule

// File: rtl/cmr_checker.sv
// Property checker for cmr_top: ready after reset, output hold under
// backpressure, packets kept contiguous, and slot conservation across lists.
module cmr_checker #(
    parameter int NCIRC      = 8,
    parameter int CNT_W      = 4,
    parameter int POOL_DEPTH = 8,
    parameter int OLBL_W     = 4,
    parameter int DATA_W     = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_ready,
    input logic                   tbl_we,
    input logic                   out_valid,
    input logic                   out_ready,
    input logic                   out_eop,
    input logic [OLBL_W-1:0]      out_label,
    input logic [DATA_W-1:0]      out_data,
    input logic [CNT_W-1:0]       fl_cnt,
    input logic [CNT_W-1:0]       ol_cnt,
    input logic [NCIRC*CNT_W-1:0] q_cnt_flat
);
    int q_sum;

    // Sum of cells held in partial packets.
    always_comb begin
        q_sum = 0;
        for (int i = 0; i < NCIRC; i++) q_sum += int'(q_cnt_flat[i*CNT_W +: CNT_W]);
    end

    AST_READY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> in_ready); // R1

    AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready && !tbl_we |=>
        out_valid && $stable(out_data) && $stable(out_eop) && $stable(out_label)); // R10

    AST_PKT_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !out_eop |=> out_valid && $stable(out_label)); // R3

    AST_POOL_CONSERVED: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fl_cnt) + int'(ol_cnt) + q_sum == POOL_DEPTH); // R8

    AST_FREE_RESERVE: assert property (@(posedge clk) disable iff (!rst_n)
        fl_cnt != '0); // R8
endmodule

bind cmr_top cmr_checker #(
    .NCIRC(NCIRC), .CNT_W(CNT_W), .POOL_DEPTH(POOL_DEPTH), .OLBL_W(OLBL_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .tbl_we(tbl_we),
    .out_valid(out_valid), .out_ready(out_ready), .out_eop(out_eop),
    .out_label(out_label), .out_data(out_data),
    .fl_cnt(fl_cnt), .ol_cnt(ol_cnt), .q_cnt_flat(q_cnt_flat)
);

// File: tb/test_cmr_top.sv
// Self-checking bench: a requirement-level model of pool occupancy, discard
// and completion order predicts every output cell.
module test_cmr_top;
    localparam int DEPTH = 8;
    localparam int NC    = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, in_eop = 1'b0, tbl_we = 1'b0, out_ready = 1'b0;
    logic       in_ready, out_valid, out_eop;
    logic [0:0] in_port = '0;
    logic [1:0] in_vci = '0;
    logic [7:0] in_data = '0, out_data;
    logic [2:0] tbl_circ = '0;
    logic [3:0] tbl_label = '0, out_label;

    int vectors = 0, errors = 0;
    int held = 0;
    int part_n [NC];
    logic [7:0] part_d [NC][DEPTH];
    bit skip_m [NC];
    logic [3:0] tbl_m [NC];
    logic [12:0] exp_q [$];
    string data_req = "R4", lbl_req = "R5";
    bit prev_stall = 1'b0;
    logic [12:0] prev_out;
    logic [31:0] rng = 32'h1234_5678;

    always #5 clk = ~clk;

    cmr_top i_cmr_top (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_port(in_port), .in_vci(in_vci), .in_eop(in_eop), .in_data(in_data),
        .tbl_we(tbl_we), .tbl_circ(tbl_circ), .tbl_label(tbl_label),
        .out_valid(out_valid), .out_ready(out_ready), .out_label(out_label),
        .out_eop(out_eop), .out_data(out_data)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Model of an input cell, using occupancy from before this edge's release.
    task automatic model_in(input int c, input bit e, input logic [7:0] d);
        if (skip_m[c]) begin
            if (e) skip_m[c] = 1'b0;
        end else if (held >= DEPTH - 1) begin
            held -= part_n[c];
            part_n[c] = 0;
            if (!e) skip_m[c] = 1'b1;
        end else begin
            part_d[c][part_n[c]] = d;
            part_n[c]++;
            held++;
            if (e) begin
                for (int i = 0; i < part_n[c]; i++)
                    exp_q.push_back({tbl_m[c], (i == part_n[c] - 1), part_d[c][i]});
                part_n[c] = 0;
            end
        end
    endtask

    // One clock: drive at the falling edge, check outputs, update the model.
    task automatic cyc(input bit v, input int c, input bit e, input logic [7:0] d, input bit ordy);
        logic [12:0] cur, ex;
        bit rel;
        in_valid = v; {in_port, in_vci} = 3'(c); in_eop = e; in_data = d; out_ready = ordy;
        #1;
        cur = {out_label, out_eop, out_data};
        chk(out_valid == (exp_q.size() != 0), "R2", "out_valid", int'(out_valid), int'(exp_q.size() != 0));
        if (prev_stall && out_valid)
            chk(cur == prev_out, "R10", "held output", int'(cur), int'(prev_out));
        rel = 1'b0;
        if (out_valid && ordy && exp_q.size() != 0) begin
            ex = exp_q.pop_front();
            chk(out_data == ex[7:0], data_req, "data", int'(out_data), int'(ex[7:0]));
            chk(out_eop == ex[8], data_req, "eop", int'(out_eop), int'(ex[8]));
            chk(out_label == ex[12:9], lbl_req, "label", int'(out_label), int'(ex[12:9]));
            rel = 1'b1;
        end
        prev_stall = out_valid && !ordy;
        prev_out = cur;
        if (v) model_in(c, e, d);
        if (rel) held--;
        @(negedge clk);
    endtask

    task automatic wr_tbl(input int c, input logic [3:0] l);
        in_valid = 1'b0; out_ready = 1'b0; tbl_we = 1'b1; tbl_circ = 3'(c); tbl_label = l;
        @(negedge clk);
        tbl_we = 1'b0;
        tbl_m[c] = l;
        prev_stall = 1'b0;
    endtask

    task automatic drain();
        int n;
        n = 0;
        while ((exp_q.size() != 0 || out_valid) && n < 100) begin
            cyc(1'b0, 0, 1'b0, 8'h00, 1'b1);
            n++;
        end
        chk(exp_q.size() == 0 && !out_valid, "R2", "drain left cells", exp_q.size(), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin : stim
        for (int i = 0; i < NC; i++) begin part_n[i] = 0; skip_m[i] = 1'b0; tbl_m[i] = '0; end
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b0, "R1", "in_ready in reset", int'(in_ready), 0);
        chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);

        // Label of circuit {port,vci}: same for both ports (full merge), class bit distinct.
        for (int c = 0; c < NC; c++) wr_tbl(c, 4'(2 + 5 * ((c >> 1) & 1) + (c & 1)));

        // R7 / R6: one-cell packets on every circuit.
        data_req = "R7"; lbl_req = "R6";
        for (int c = 0; c < NC; c++) cyc(1'b1, c, 1'b1, 8'(c * 16 + 1), 1'b1);
        drain();

        // R3 R4: interleave two circuits over all ordered pairs, with backpressure.
        data_req = "R3 R4"; lbl_req = "R5";
        for (int a = 0; a < NC; a++) begin
            for (int b = 0; b < NC; b++) begin
                if (a != b) begin
                    int la, lb, k;
                    la = 1 + a % 3; lb = 2 + b % 2; k = 0;
                    for (int s = 0; s < 3; s++) begin
                        if (s < la) cyc(1'b1, a, s == la - 1, 8'(a * 32 + b * 4 + s), (k % 4) != 1);
                        k++;
                        if (s < lb) cyc(1'b1, b, s == lb - 1, 8'(b * 32 + a * 4 + s + 128), (k % 4) != 1);
                        k++;
                    end
                end
            end
        end
        drain();

        // R9: pool full drops a cell, discards the partial packet, skips to its end.
        data_req = "R9";
        for (int s = 0; s < 4; s++) cyc(1'b1, 1, 1'b0, 8'(8'h10 + s), 1'b0);
        for (int s = 0; s < 3; s++) cyc(1'b1, 6, s == 2, 8'(8'h60 + s), 1'b0);
        cyc(1'b1, 1, 1'b0, 8'h14, 1'b0);
        cyc(1'b1, 1, 1'b0, 8'h15, 1'b0);
        cyc(1'b1, 1, 1'b1, 8'h16, 1'b0);
        cyc(1'b1, 2, 1'b0, 8'h20, 1'b0);
        cyc(1'b1, 2, 1'b1, 8'h21, 1'b0);
        chk(held == 5, "R9", "model occupancy", held, 5);
        drain();

        // R8: one circuit fills the whole usable pool; the next cell is dropped.
        data_req = "R8";
        for (int s = 0; s < DEPTH - 1; s++) cyc(1'b1, 5, s == DEPTH - 2, 8'(8'h50 + s), 1'b0);
        cyc(1'b1, 0, 1'b1, 8'hEE, 1'b0);
        drain();

        // R10: release and completion on one edge, then release and drop on one edge.
        data_req = "R10";
        cyc(1'b1, 3, 1'b1, 8'h33, 1'b0);
        cyc(1'b1, 4, 1'b0, 8'h40, 1'b0);
        cyc(1'b0, 0, 1'b0, 8'h00, 1'b0);
        cyc(1'b1, 4, 1'b1, 8'h41, 1'b1);
        drain();
        for (int s = 0; s < DEPTH - 1; s++) cyc(1'b1, 7, s == DEPTH - 2, 8'(8'h70 + s), 1'b0);
        cyc(1'b1, 0, 1'b1, 8'hAB, 1'b1);
        cyc(1'b1, 0, 1'b1, 8'hAC, 1'b1);
        drain();

        // Pseudo-random traffic with random backpressure.
        data_req = "R4";
        for (int n = 0; n < 5000; n++) begin
            rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
            cyc(rng[0] | rng[1], int'(rng[4:2]), rng[7:5] < 3'd2, rng[17:10], rng[9:8] != 2'd0);
        end
        for (int c = 0; c < NC; c++) if (part_n[c] != 0 || skip_m[c]) cyc(1'b1, c, 1'b1, 8'(c), 1'b1);
        drain();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule